// File: doc/BRIEF.md
# Circular Trace Buffer Sink Controller

This block takes a byte-wide trace stream and stores it into a memory window that software describes with a base address and a limit address. Bytes are placed at the current write pointer, which climbs one byte per stored entry. When the byte at the address just below the limit has been stored, the pointer returns to the base address. In fill mode this wrap stops capture and raises a maintenance interrupt together with a structured status word. In wrap mode the same event is reported but capture continues, overwriting the oldest data.

Software programs the base and the write pointer while capture is off, then writes the limit register, which also carries the enable bit and the mode fields. The block accepts bytes through a valid/ready handshake into a small queue and then issues single-byte memory writes that the memory side may stall. Before turning capture off, software can raise a drain request and wait for an acknowledge, so that no accepted byte is left in the queue.

Top module: `tcb_sink`

## Requirements
- R1: After reset every register reads zero, and `in_ready`, `mem_we`, `irq` and `drain_ack` are low.
- R2: Register select 0 holds the base address, with the low PAGE_LOG2 (default 12) bits forced to zero on write. Register select 1 holds the write pointer, with the low ALIGN_LOG2 (default 4) bits forced to zero on a software write. Register select 4 is read-only and returns ALIGN_LOG2 in bits [3:0]. Unused selects read zero.
- R3: Register select 2 is the limit register. Bits [31:12] hold the page-aligned limit, bit 0 holds enable, bits [2:1] hold the mode (01 = wrap mode, any other value = fill mode), bits [4:3] hold a stored-only trigger mode and bit 5 holds a stored-only non-volatile-memory flag. Other bits read zero. Clearing only the enable bit leaves the limit readable.
- R4: A write that sets the enable bit takes effect only when base <= write pointer < the newly written limit. Otherwise the enable bit reads back 0.
- R5: Writes to the base or write-pointer registers are ignored while enable is set.
- R6: Accepted bytes are written to memory in arrival order, one per cycle in which `mem_we` and `mem_ready` are both high. `mem_addr` is the write pointer, which then advances by one.
- R7: `in_ready` is low whenever enable is clear, the status stop flag is set, `drain_req` is high or the queue is full.
- R8: In fill mode, storing the byte at limit-1 returns the write pointer to base and sets irq, wrap and stop, with exception class 0 ("other") in status [9:4] and buffer status code 1 ("filled") in status [15:10]. The trigger flag keeps its value. Capture halts, and bytes still queued are discarded.
- R9: In wrap mode, storing the byte at limit-1 returns the pointer to base and sets the irq and wrap flags, and capture continues.
- R10: Register select 3 is the status register: bit 0 irq, bit 1 trigger, bit 2 wrap, bit 3 stop, [9:4] exception class, [15:10] buffer status code. A software write replaces it, and a hardware event in the same cycle takes priority. `irq` equals bit 0. While stop is set, nothing is captured or written, even with enable set.
- R11: Memory writes happen only while enabled and not stopped. Queued bytes are kept while disabled and resume after a re-enable. `drain_ack` is high exactly when `drain_req` is high and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| in_valid | input | 1 | Trace byte valid |
| in_data | input | 8 | Trace byte |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| mem_we | output | 1 | Memory byte write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory byte data |
| mem_ready | input | 1 | Memory takes the write this cycle |
| drain_req | input | 1 | Request to empty the queue |
| drain_ack | output | 1 | Queue empty while drain is requested |
| irq | output | 1 | Maintenance interrupt, level |

## Verification
The assertions assume a clean asynchronous reset. They also assume that all inputs change only between clock edges, since the handshake checks sample `in_valid`, `mem_ready` and `drain_req` as single-cycle levels. The address-range check depends on the pointer order that the enable gate enforces, so the stimulus may write illegal pointer orders and locked registers on purpose without breaking it. Every input is driven one nanosecond after a rising edge, and results are compared on the falling edge against a behavioural model that holds the queue as a list.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  localparam int unsigned TCB_AW    = 32;
  localparam int unsigned TCB_BW    = 8;
  localparam int unsigned TCB_SEL_W = 3;

  typedef logic [TCB_AW-1:0] addr_t;

  typedef enum logic [TCB_SEL_W-1:0] {
    RS_BASE  = 3'd0,
    RS_WPTR  = 3'd1,
    RS_LIMIT = 3'd2,
    RS_STAT  = 3'd3,
    RS_IDENT = 3'd4
  } reg_sel_e;

  localparam int unsigned LIM_EN_BIT   = 0;
  localparam int unsigned LIM_MODE_LSB = 1;
  localparam int unsigned LIM_TRIG_LSB = 3;
  localparam int unsigned LIM_NVM_BIT  = 5;

  localparam logic [1:0] MODE_WRAP = 2'b01;
  localparam logic [5:0] EC_OTHER   = 6'd0;
  localparam logic [5:0] BSC_FILLED = 6'd1;

  typedef struct packed {
    logic [5:0] bsc;
    logic [5:0] ec;
    logic       stop;
    logic       wrap;
    logic       trig;
    logic       irq;
  } stat_t;

  function automatic addr_t floor_pow2(addr_t a, int unsigned lg);
    return a & ~((addr_t'(1) << lg) - addr_t'(1));
  endfunction

  function automatic logic order_ok(addr_t b, addr_t w, addr_t l);
    return (b <= w) && (w < l);
  endfunction

  function automatic logic at_last(addr_t w, addr_t l);
    return w == (l - addr_t'(1));
  endfunction

  function automatic logic mode_fills(logic [1:0] m);
    return m != MODE_WRAP;
  endfunction
endpackage

// File: rtl/tcb_fifo.sv
`timescale 1ns/1ps
module tcb_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
  logic [CW-1:0] count;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_inc = wr_ptr + PW'(1);
      assign rd_inc = rd_ptr + PW'(1);
    end else begin : g_mod
      assign wr_inc = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_inc = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    end
  endgenerate

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) slot[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_inc;
      if (pop)  rd_ptr <= rd_inc;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R7
  fifo_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6
  fifo_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tcb_regs.sv
`timescale 1ns/1ps
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int PAGE_LOG2  = 12,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [TCB_SEL_W-1:0] reg_addr,
  input  addr_t                reg_wdata,
  output addr_t                reg_rdata,
  input  logic                 pop,
  input  logic                 wrap_evt,
  input  logic                 fill_evt,
  input  addr_t                wptr_next,
  output addr_t                base_q,
  output addr_t                wptr_q,
  output addr_t                lim_q,
  output logic                 en_q,
  output logic [1:0]           mode_q,
  output stat_t                stat_q
);
  localparam addr_t ID_WORD = addr_t'(ALIGN_LOG2);

  reg_sel_e   sel;
  logic [1:0] trig_q;
  logic       nvm_q;
  logic       wr_base, wr_wptr, wr_lim, wr_stat;
  addr_t      lim_new;
  logic       en_grant;
  stat_t      fill_word, wrap_word;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_base  = reg_we && (sel == RS_BASE) && !en_q;
  assign wr_wptr  = reg_we && (sel == RS_WPTR) && !en_q;
  assign wr_lim   = reg_we && (sel == RS_LIMIT);
  assign wr_stat  = reg_we && (sel == RS_STAT);
  assign lim_new  = floor_pow2(reg_wdata, PAGE_LOG2);
  assign en_grant = reg_wdata[LIM_EN_BIT] && order_ok(base_q, wptr_q, lim_new);

  always_comb begin
    fill_word      = stat_q;
    fill_word.irq  = 1'b1;
    fill_word.wrap = 1'b1;
    fill_word.stop = 1'b1;
    fill_word.ec   = EC_OTHER;
    fill_word.bsc  = BSC_FILLED;
    wrap_word      = stat_q;
    wrap_word.irq  = 1'b1;
    wrap_word.wrap = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wptr_q <= '0;
      lim_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= '0;
      trig_q <= '0;
      nvm_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_base) base_q <= floor_pow2(reg_wdata, PAGE_LOG2);
      if (pop)          wptr_q <= wptr_next;
      else if (wr_wptr) wptr_q <= floor_pow2(reg_wdata, ALIGN_LOG2);
      if (wr_lim) begin
        lim_q  <= lim_new;
        en_q   <= en_grant;
        mode_q <= reg_wdata[LIM_MODE_LSB +: 2];
        trig_q <= reg_wdata[LIM_TRIG_LSB +: 2];
        nvm_q  <= reg_wdata[LIM_NVM_BIT];
      end
      if (fill_evt)      stat_q <= fill_word;
      else if (wrap_evt) stat_q <= wrap_word;
      else if (wr_stat)  stat_q <= stat_t'(reg_wdata[$bits(stat_t)-1:0]);
    end
  end

  always_comb begin
    case (sel)
      RS_BASE:  reg_rdata = base_q;
      RS_WPTR:  reg_rdata = wptr_q;
      RS_LIMIT: reg_rdata = lim_q | addr_t'({nvm_q, trig_q, mode_q, en_q});
      RS_STAT:  reg_rdata = addr_t'(stat_q);
      RS_IDENT: reg_rdata = ID_WORD;
      default:  reg_rdata = '0;
    endcase
  end

  // R5
  base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> base_q == $past(base_q));
  // R4
  enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> order_ok(base_q, wptr_q, lim_q));
  // R8
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> wptr_q == $past(base_q));
  // R8
  fill_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (stat_q.stop && stat_q.irq && stat_q.bsc == BSC_FILLED));
endmodule

// File: rtl/tcb_wr_engine.sv
`timescale 1ns/1ps
module tcb_wr_engine
  import tcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stopped,
  input  logic              fifo_empty,
  input  logic [TCB_BW-1:0] fifo_head,
  input  logic              mem_ready,
  input  addr_t             base,
  input  addr_t             wptr,
  input  addr_t             lim,
  input  logic [1:0]        mode,
  output logic              mem_we,
  output addr_t             mem_addr,
  output logic [TCB_BW-1:0] mem_data,
  output logic              pop,
  output logic              wrap_evt,
  output logic              fill_evt,
  output addr_t             wptr_next
);
  logic run, last;

  assign run       = en && !stopped;
  assign mem_we    = run && !fifo_empty;
  assign mem_addr  = wptr;
  assign mem_data  = fifo_head;
  assign pop       = mem_we && mem_ready;
  assign last      = at_last(wptr, lim);
  assign wrap_evt  = pop && last;
  assign fill_evt  = wrap_evt && mode_fills(mode);
  assign wptr_next = last ? base : wptr + addr_t'(1);

  // R6
  mem_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= base && mem_addr < lim));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wrap_evt) |=> wptr == $past(wptr) + addr_t'(1));
endmodule

// File: rtl/tcb_sink.sv
`timescale 1ns/1ps
module tcb_sink
  import tcb_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int PAGE_LOG2  = 12,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  output logic         in_ready,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [7:0]   mem_data,
  input  logic         mem_ready,
  input  logic         drain_req,
  output logic         drain_ack,
  output logic         irq
);
  addr_t             base_q, wptr_q, lim_q, wptr_next;
  logic              en_q;
  logic [1:0]        mode_q;
  stat_t             stat_q;
  logic              push, pop, wrap_evt, fill_evt;
  logic              fifo_empty, fifo_full;
  logic [TCB_BW-1:0] fifo_head;

  assign in_ready  = en_q && !stat_q.stop && !drain_req && !fifo_full;
  assign push      = in_valid && in_ready;
  assign drain_ack = drain_req && fifo_empty;
  assign irq       = stat_q.irq;

  tcb_regs #(.PAGE_LOG2(PAGE_LOG2), .ALIGN_LOG2(ALIGN_LOG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop),
    .wrap_evt(wrap_evt), .fill_evt(fill_evt), .wptr_next(wptr_next),
    .base_q(base_q), .wptr_q(wptr_q), .lim_q(lim_q), .en_q(en_q),
    .mode_q(mode_q), .stat_q(stat_q)
  );

  tcb_fifo #(.DEPTH(FIFO_DEPTH), .W(TCB_BW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fill_evt), .push(push), .din(in_data),
    .pop(pop), .dout(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  tcb_wr_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_q), .stopped(stat_q.stop),
    .fifo_empty(fifo_empty), .fifo_head(fifo_head), .mem_ready(mem_ready),
    .base(base_q), .wptr(wptr_q), .lim(lim_q), .mode(mode_q),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .pop(pop),
    .wrap_evt(wrap_evt), .fill_evt(fill_evt), .wptr_next(wptr_next)
  );

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || stat_q.stop || drain_req) |-> !in_ready);
  // R11
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ack |-> !mem_we);
  // R8
  fill_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (irq && !in_ready && !mem_we));
  // R11
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !mem_we);
endmodule

// File: tb/tcb_sink_bench.sv
`timescale 1ns/1ps
module tcb_sink_bench;
  localparam int DEPTH = 8;
  localparam int ALG   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0, mem_data;
  logic mem_we, mem_ready = 1'b0, drain_req = 1'b0, drain_ack, irq;
  logic [31:0] mem_addr;

  tcb_sink #(.FIFO_DEPTH(DEPTH), .PAGE_LOG2(12), .ALIGN_LOG2(ALG)) u_tcb_sink (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .drain_req(drain_req), .drain_ack(drain_ack), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model
  logic [7:0]  q[$];
  logic [31:0] m_base, m_wptr, m_lim, nl;
  bit          m_en, m_nvm, old_en, mp, mpush, mlast, mfill;
  logic [1:0]  m_mode, m_trig;
  logic [15:0] m_stat;

  function automatic bit x_rdy();
    return m_en && !m_stat[3] && !drain_req && (q.size() < DEPTH);
  endfunction
  function automatic bit x_we();
    return m_en && !m_stat[3] && (q.size() > 0);
  endfunction
  function automatic logic [31:0] x_rd(logic [2:0] a);
    case (a)
      3'd0: return m_base;
      3'd1: return m_wptr;
      3'd2: return m_lim | {26'd0, m_nvm, m_trig, m_mode, m_en};
      3'd3: return {16'd0, m_stat};
      3'd4: return ALG;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_base = 0; m_wptr = 0; m_lim = 0; m_en = 0; m_nvm = 0;
      m_mode = 0; m_trig = 0; m_stat = 0;
    end else begin
      old_en = m_en;
      mp     = x_we() && mem_ready;
      mpush  = in_valid && x_rdy();
      mlast  = mp && (m_wptr == m_lim - 1);
      mfill  = mlast && (m_mode != 2'b01);
      nl     = reg_wdata & ~32'hFFF;
      if (mp) void'(q.pop_front());
      if (mpush) q.push_back(in_data);
      if (mfill) q.delete();
      if (reg_we && reg_addr == 3'd2) begin
        m_en   = reg_wdata[0] && (m_base <= m_wptr) && (m_wptr < nl);
        m_lim  = nl;
        m_mode = reg_wdata[2:1];
        m_trig = reg_wdata[4:3];
        m_nvm  = reg_wdata[5];
      end
      if (reg_we && reg_addr == 3'd0 && !old_en) m_base = reg_wdata & ~32'hFFF;
      if (mp) m_wptr = mlast ? m_base : m_wptr + 1;
      else if (reg_we && reg_addr == 3'd1 && !old_en) m_wptr = reg_wdata & ~32'hF;
      if (mfill) m_stat = (m_stat & 16'h0002) | 16'h040D;
      else if (mlast) m_stat = m_stat | 16'h0005;
      else if (reg_we && reg_addr == 3'd3) m_stat = reg_wdata[15:0];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 in_ready", in_ready, x_rdy());
      chk("R11 mem_we", mem_we, x_we());
      if (x_we()) begin
        chk("R6 mem_addr", mem_addr, m_wptr);
        chk("R6 mem_data", mem_data, q[0]);
      end
      chk("R10 irq", irq, m_stat[0]);
      chk("R11 drain_ack", drain_ack, drain_req && q.size() == 0);
      chk("R3 reg_rdata", reg_rdata, x_rd(reg_addr));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    @(posedge clk); #1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stream(int n, int pv, int pr);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid  = ($urandom % 100) < pv;
      in_data   = 8'($urandom);
      mem_ready = ($urandom % 100) < pr;
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w0, wexp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", in_ready, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 irq", irq, 0);
    chk("R1 drain_ack", drain_ack, 0);
    @(posedge clk); #1;
    rd(3'd2, v); chk("R1 limit", v, 0);
    rd(3'd3, v); chk("R1 status", v, 0);

    // R2 alignment and identity
    wr(3'd0, 32'h1234_5678); rd(3'd0, v); chk("R2 base floor", v, 32'h1234_5000);
    wr(3'd1, 32'h1234_56FF); rd(3'd1, v); chk("R2 wptr floor", v, 32'h1234_56F0);
    rd(3'd4, v); chk("R2 ident", v, ALG);
    rd(3'd6, v); chk("R2 unused select", v, 0);

    // R4 refused enable, R3 field layout
    wr(3'd0, 32'h1000); wr(3'd1, 32'h3000);
    wr(3'd2, 32'h2000 | 32'h38 | 32'h1);
    rd(3'd2, v); chk("R4 enable refused", v, 32'h2038);
    chk("R3 limit readable", v & 32'hFFFF_F000, 32'h2000);

    // R4 accepted enable in fill mode, R5 locked base
    wr(3'd1, 32'h1FE0); wr(3'd2, 32'h2001);
    rd(3'd2, v); chk("R4 enable granted", v, 32'h2001);
    wr(3'd0, 32'h5000); rd(3'd0, v); chk("R5 base ignored", v, 32'h1000);
    wr(3'd1, 32'h1100); rd(3'd1, v); chk("R5 wptr ignored", v, 32'h1FE0);

    // R8 fill-mode stop
    stream(200, 70, 60);
    rd(3'd3, v); chk("R8 status word", v, 32'h040D);
    rd(3'd1, v); chk("R8 wptr at base", v, 32'h1000);
    chk("R8 irq", irq, 1);
    chk("R8 halted", in_ready, 0);

    // R10 stop keeps capture halted, irq follows bit 0
    wr(3'd3, 32'h0008);
    @(negedge clk);
    chk("R10 irq low", irq, 0);
    chk("R10 stop halts", in_ready, 0);
    @(posedge clk); #1;
    wr(3'd3, 32'h0);

    // R9 wrap mode continues
    wr(3'd2, 32'h2000);
    wr(3'd1, 32'h1FF0);
    wr(3'd2, 32'h2003);
    stream(150, 70, 70);
    rd(3'd3, v); chk("R9 status wrap", v, 32'h0005);

    // R11 drain
    mem_ready = 1; cyc(12);
    mem_ready = 0; in_valid = 1; in_data = 8'hA5;
    cyc(5);
    in_valid = 0; drain_req = 1;
    @(negedge clk);
    chk("R11 ack waits", drain_ack, 0);
    chk("R7 ready during drain", in_ready, 0);
    @(posedge clk); #1;
    mem_ready = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (drain_ack) break;
    end
    chk("R11 ack when empty", drain_ack, 1);
    chk("R11 idle at ack", mem_we, 0);
    @(posedge clk); #1;
    drain_req = 0;

    // R11 queued bytes survive a disable
    mem_ready = 0; in_valid = 1; in_data = 8'h3C;
    cyc(3);
    in_valid = 0;
    rd(3'd1, w0);
    wr(3'd2, 32'h2002);
    mem_ready = 1; cyc(5);
    @(negedge clk);
    chk("R11 no write while off", mem_we, 0);
    @(posedge clk); #1;
    rd(3'd1, v); chk("R11 pointer held", v, w0);
    wr(3'd2, 32'h2003);
    cyc(10);
    wexp = (w0 + 3 >= 32'h2000) ? w0 + 3 - 32'h1000 : w0 + 3;
    rd(3'd1, v); chk("R6 resumed pointer", v, wexp);

    done = 1;
    summary();
    $finish;
  end
endmodule